// File: doc/BRIEF.md
# Nibble Data Memory Access Unit

This unit performs every data-memory access of a small 4-bit accumulator controller. It holds two index registers: a 3-bit page register X and a 4-bit word register Y. It forms the RAM address either from X above Y, trimmed by a configurable mask, or from a 2-bit direct field taken from the command immediate. It carries out nibble loads and stores, with variants that step Y up or down after the access. It also runs read-modify-write commands on a memory nibble: increment, decrement, set bits and clear bits.

Commands arrive already decoded, as an operation code and a 4-bit immediate, over a valid/ready handshake. The sender must hold `cmd_valid`, `cmd_op`, `cmd_imm` and `acc_in` steady until a cycle in which `cmd_ready` is high. `cmd_ready` drops for one cycle while a two-phase command finishes, and it stays low while `clk_en` is low. The unit latches the accumulator value when it accepts a command. Results for the accumulator, zero flag and carry flag appear on the cycle after the command completes, marked by `res_valid` together with a write enable per field. The RAM itself sits outside the unit and is read combinationally.

Top module: `nibble_mem_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears X and Y to 0 and `res_valid` to 0. With `clk_en` high, `cmd_ready` is 1 after reset.
- R2: Indexed commands drive `mem_addr` = {X, Y} AND `DATA_MASK`, with X in the upper bits and Y in the low 4 bits. The indexed commands are load (op 1), load-inc (3), load-dec (4), store (5), store-inc (7), store-dec (8), inc-mem (14), dec-mem (15), set-bits (16) and clear-bits (17).
- R3: Direct load (op 2) and direct store (op 6) ignore X and Y. They drive `mem_addr` = `cmd_imm[1:0]`, zero-extended.
- R4: Load-X (op 9) sets X to `cmd_imm[2:0]`. Load-Y (op 10) sets Y to `cmd_imm`.
- R5: Load (op 1) and direct load (op 2) finish in one cycle. They return `mem_rdata[3:0]` with `res_acc_we`=1 and `res_zf` = (value == 0). The upper bits of `mem_rdata` are ignored.
- R6: Store (op 1 cycle: op 5 and op 6) writes `acc_in` as `mem_wdata` during the accept cycle, with one `mem_we` pulse.
- R7: Load-inc/dec (ops 3/4) and store-inc/dec (ops 7/8) take two cycles. The access goes to the address formed from the old Y. Y then becomes Y±1 modulo 16, and `res_zf` (with `res_zf_we`=1) reflects whether the new Y is 0. The load variants also return the nibble with `res_acc_we`=1.
- R8: Inc-mem (op 14) and dec-mem (op 15) take two cycles. They read the nibble, form the 5-bit value nibble±1, and write its low 4 bits back. `res_cf` is bit 4 of that value and `res_zf` is true when its low 4 bits are 0.
- R9: Set-bits (op 16) writes nibble OR `cmd_imm`. Clear-bits (op 17) writes nibble AND NOT `cmd_imm`. Both take two cycles and report no flags.
- R10: Op 11 copies `acc_in[2:0]` to X. Op 12 copies `acc_in` to Y. Op 13 returns Y as the accumulator result with `res_zf` = (Y == 0).
- R11: `cmd_ready` is 0 whenever `clk_en` is 0 and during the second phase of a two-phase command. While `clk_en` is 0, X, Y, the state and `mem_we` stay unchanged or inactive.
- R12: Each store or read-modify-write command produces exactly one `mem_we` pulse, issued in its write cycle. Loads and register commands produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; when low, the unit holds its state |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted at this edge when valid |
| cmd_op | input | 5 | Decoded operation code |
| cmd_imm | input | 4 | Immediate nibble from the opcode |
| acc_in | input | 4 | Accumulator value |
| mem_addr | output | XW+YW (7) | RAM address |
| mem_wdata | output | 4 | RAM write nibble |
| mem_we | output | 1 | RAM write strobe |
| mem_rdata | input | BUSW (8) | RAM read data; only the low nibble is used |
| x_out | output | XW (3) | Current X |
| y_out | output | YW (4) | Current Y |
| res_valid | output | 1 | Result fields valid this cycle |
| res_acc_we | output | 1 | Accumulator result present |
| res_acc | output | 4 | Accumulator result |
| res_zf_we | output | 1 | Zero flag result present |
| res_zf | output | 1 | Zero flag result |
| res_cf_we | output | 1 | Carry flag result present |
| res_cf | output | 1 | Carry flag result |

## Verification
The assertions rely on a sender that keeps a command steady until it is accepted and never issues undefined operation codes. They also rely on reset being asserted from time zero. The stimulus issues each command from the falling edge, holds it until `cmd_ready` has been seen, and then drops `cmd_valid` for at least one cycle. As a result, back-to-back store pulses never touch each other. `clk_en` is lowered only in the dedicated stall sequence, and that sequence covers both the idle state and the middle of a read-modify-write.

// File: rtl/nmau_pkg.sv
package nmau_pkg;

  typedef enum logic [4:0] {
    OP_NOP   = 5'd0,
    OP_LD    = 5'd1,
    OP_LDD   = 5'd2,
    OP_LDINC = 5'd3,
    OP_LDDEC = 5'd4,
    OP_ST    = 5'd5,
    OP_STD   = 5'd6,
    OP_STINC = 5'd7,
    OP_STDEC = 5'd8,
    OP_LX    = 5'd9,
    OP_LY    = 5'd10,
    OP_TAX   = 5'd11,
    OP_TAY   = 5'd12,
    OP_TYA   = 5'd13,
    OP_INCM  = 5'd14,
    OP_DECM  = 5'd15,
    OP_SETB  = 5'd16,
    OP_CLRB  = 5'd17
  } nm_op_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_PHASE2 = 1'b1
  } nm_state_e;

  function automatic logic op_direct(nm_op_e op);
    return (op == OP_LDD) || (op == OP_STD);
  endfunction

  function automatic logic op_y_step(nm_op_e op);
    return (op == OP_LDINC) || (op == OP_LDDEC) || (op == OP_STINC) || (op == OP_STDEC);
  endfunction

  function automatic logic op_y_down(nm_op_e op);
    return (op == OP_LDDEC) || (op == OP_STDEC);
  endfunction

  function automatic logic op_rmw(nm_op_e op);
    return (op == OP_INCM) || (op == OP_DECM) || (op == OP_SETB) || (op == OP_CLRB);
  endfunction

  function automatic logic op_two_phase(nm_op_e op);
    return op_y_step(op) || op_rmw(op);
  endfunction

  function automatic logic op_ph2_write(nm_op_e op);
    return (op == OP_STINC) || (op == OP_STDEC) || op_rmw(op);
  endfunction

endpackage

// File: rtl/nmau_addr_gen.sv
module nmau_addr_gen #(
  parameter int XW = 3,
  parameter int YW = 4,
  parameter int DIRW = 2,
  parameter logic [XW+YW-1:0] MASK = '1
) (
  input  logic [XW-1:0]    x,
  input  logic [YW-1:0]    y,
  input  logic             direct,
  input  logic [DIRW-1:0]  dir_field,
  output logic [XW+YW-1:0] addr
);
  localparam int AW = XW + YW;

  logic [AW-1:0] indexed;
  logic [AW-1:0] direct_addr;

  assign indexed     = {x, y} & MASK;
  assign direct_addr = AW'(dir_field);
  assign addr        = direct ? direct_addr : indexed;
endmodule

// File: rtl/nmau_index_regs.sv
module nmau_index_regs #(
  parameter int XW = 3,
  parameter int YW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          x_ld,
  input  logic [XW-1:0] x_nxt,
  input  logic          y_ld,
  input  logic [YW-1:0] y_nxt,
  output logic [XW-1:0] x_q,
  output logic [YW-1:0] y_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (en) begin
      if (x_ld) x_q <= x_nxt;
      if (y_ld) y_q <= y_nxt;
    end
  end
endmodule

// File: rtl/nmau_rmw_alu.sv
module nmau_rmw_alu
  import nmau_pkg::*;
#(
  parameter int NIB = 4
) (
  input  nm_op_e         op,
  input  logic [NIB-1:0] rd,
  input  logic [NIB-1:0] imm,
  output logic [NIB-1:0] wr,
  output logic           cf,
  output logic           zf
);
  logic [NIB:0] wide;

  always_comb begin
    case (op)
      OP_INCM: wide = {1'b0, rd} + (NIB+1)'(1);
      OP_DECM: wide = {1'b0, rd} - (NIB+1)'(1);
      OP_SETB: wide = {1'b0, rd | imm};
      OP_CLRB: wide = {1'b0, rd & ~imm};
      default: wide = {1'b0, rd};
    endcase
  end

  assign wr = wide[NIB-1:0];
  assign cf = wide[NIB];
  assign zf = (wide[NIB-1:0] == '0);
endmodule

// File: rtl/nibble_mem_unit.sv
module nibble_mem_unit
  import nmau_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 4,
  parameter int BUSW = 8,
  parameter logic [XW+YW-1:0] DATA_MASK = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clk_en,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [4:0]         cmd_op,
  input  logic [3:0]         cmd_imm,
  input  logic [3:0]         acc_in,
  output logic [XW+YW-1:0]   mem_addr,
  output logic [3:0]         mem_wdata,
  output logic               mem_we,
  input  logic [BUSW-1:0]    mem_rdata,
  output logic [XW-1:0]      x_out,
  output logic [YW-1:0]      y_out,
  output logic               res_valid,
  output logic               res_acc_we,
  output logic [3:0]         res_acc,
  output logic               res_zf_we,
  output logic               res_zf,
  output logic               res_cf_we,
  output logic               res_cf
);
  localparam int NIB  = 4;
  localparam int AW   = XW + YW;
  localparam int DIRW = 2;

  nm_op_e        in_op;
  nm_state_e     state_q;
  nm_op_e        op_q;
  logic [NIB-1:0] imm_q, acc_q, rd_q;
  logic [AW-1:0]  addr_q, addr_now;
  logic [NIB-1:0] rd_nib;
  logic           in_idle, fire, ph2_done, single_done;
  logic [NIB-1:0] alu_wr;
  logic           alu_cf, alu_zf;
  logic           x_ld, y_ld;
  logic [XW-1:0]  x_nxt;
  logic [YW-1:0]  y_nxt, y_stepped;
  logic           unused_bits;

  assign in_op       = nm_op_e'(cmd_op);
  assign in_idle     = (state_q == ST_IDLE);
  assign cmd_ready   = clk_en & in_idle;
  assign fire        = cmd_valid & cmd_ready;
  assign ph2_done    = ~in_idle & clk_en;
  assign single_done = fire & ~op_two_phase(in_op);
  assign rd_nib      = mem_rdata[NIB-1:0];
  assign unused_bits = ^mem_rdata[BUSW-1:NIB];

  nmau_addr_gen #(.XW(XW), .YW(YW), .DIRW(DIRW), .MASK(DATA_MASK)) u_addr (
    .x         (x_out),
    .y         (y_out),
    .direct    (op_direct(in_op)),
    .dir_field (cmd_imm[DIRW-1:0]),
    .addr      (addr_now)
  );

  assign mem_addr = in_idle ? addr_now : addr_q;

  nmau_rmw_alu #(.NIB(NIB)) u_alu (
    .op  (op_q),
    .rd  (rd_q),
    .imm (imm_q),
    .wr  (alu_wr),
    .cf  (alu_cf),
    .zf  (alu_zf)
  );

  assign mem_we = (fire & ((in_op == OP_ST) | (in_op == OP_STD)))
                | (ph2_done & op_ph2_write(op_q));

  always_comb begin
    if (in_idle)            mem_wdata = acc_in;
    else if (op_rmw(op_q))  mem_wdata = alu_wr;
    else                    mem_wdata = acc_q;
  end

  assign y_stepped = op_y_down(op_q) ? (y_out - YW'(1)) : (y_out + YW'(1));

  always_comb begin
    x_ld  = 1'b0;
    x_nxt = x_out;
    y_ld  = 1'b0;
    y_nxt = y_out;
    if (fire) begin
      case (in_op)
        OP_LX:  begin x_ld = 1'b1; x_nxt = cmd_imm[XW-1:0]; end
        OP_TAX: begin x_ld = 1'b1; x_nxt = acc_in[XW-1:0];  end
        OP_LY:  begin y_ld = 1'b1; y_nxt = cmd_imm[YW-1:0]; end
        OP_TAY: begin y_ld = 1'b1; y_nxt = acc_in[YW-1:0];  end
        default: ;
      endcase
    end else if (ph2_done && op_y_step(op_q)) begin
      y_ld  = 1'b1;
      y_nxt = y_stepped;
    end
  end

  nmau_index_regs #(.XW(XW), .YW(YW)) u_idx (
    .clk   (clk),
    .rst   (rst),
    .en    (clk_en),
    .x_ld  (x_ld),
    .x_nxt (x_nxt),
    .y_ld  (y_ld),
    .y_nxt (y_nxt),
    .x_q   (x_out),
    .y_q   (y_out)
  );

  // Sequencing and command latch
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NOP;
      imm_q   <= '0;
      acc_q   <= '0;
      rd_q    <= '0;
      addr_q  <= '0;
    end else if (fire) begin
      op_q    <= in_op;
      imm_q   <= cmd_imm;
      acc_q   <= acc_in;
      rd_q    <= rd_nib;
      addr_q  <= addr_now;
      state_q <= op_two_phase(in_op) ? ST_PHASE2 : ST_IDLE;
    end else if (ph2_done) begin
      state_q <= ST_IDLE;
    end
  end

  // Result register
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_acc_we <= 1'b0;
      res_acc    <= '0;
      res_zf_we  <= 1'b0;
      res_zf     <= 1'b0;
      res_cf_we  <= 1'b0;
      res_cf     <= 1'b0;
    end else if (clk_en) begin
      res_valid  <= single_done | ph2_done;
      res_acc_we <= 1'b0;
      res_zf_we  <= 1'b0;
      res_cf_we  <= 1'b0;
      if (single_done) begin
        case (in_op)
          OP_LD, OP_LDD: begin
            res_acc_we <= 1'b1;
            res_acc    <= rd_nib;
            res_zf_we  <= 1'b1;
            res_zf     <= (rd_nib == '0);
          end
          OP_TYA: begin
            res_acc_we <= 1'b1;
            res_acc    <= NIB'(y_out);
            res_zf_we  <= 1'b1;
            res_zf     <= (y_out == '0);
          end
          default: ;
        endcase
      end else if (ph2_done) begin
        if (op_y_step(op_q)) begin
          res_zf_we <= 1'b1;
          res_zf    <= (y_stepped == '0);
          if (!op_ph2_write(op_q)) begin
            res_acc_we <= 1'b1;
            res_acc    <= rd_nib;
          end
        end else if ((op_q == OP_INCM) || (op_q == OP_DECM)) begin
          res_zf_we <= 1'b1;
          res_zf    <= alu_zf;
          res_cf_we <= 1'b1;
          res_cf    <= alu_cf;
        end
      end
    end
  end
endmodule

// File: rtl/nmau_chk.sv
module nmau_chk #(
  parameter int XW = 3,
  parameter int YW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clk_en,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [4:0]       cmd_op,
  input logic [3:0]       cmd_imm,
  input logic             mem_we,
  input logic [XW+YW-1:0] mem_addr,
  input logic [XW-1:0]    x_out,
  input logic [YW-1:0]    y_out,
  input logic             res_valid,
  input logic             res_cf_we,
  input logic             res_zf_we
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $fell(rst) |-> (x_out == '0) && (y_out == '0) && !res_valid);

  // R11
  stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |-> !cmd_ready && !mem_we);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(x_out) && $stable(y_out));

  // R3
  direct_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_op == 5'd6)) |->
      (mem_addr == (XW+YW)'(cmd_imm[1:0])) && mem_we);

  // R12
  load_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_op <= 5'd4)) |-> !mem_we);

  // R8
  carry_has_zero_chk: assert property (@(posedge clk) disable iff (rst)
    res_cf_we |-> res_zf_we && res_valid);
endmodule

bind nibble_mem_unit nmau_chk #(.XW(XW), .YW(YW)) u_chk (.*);

// File: tb/sim_nibble_mem_unit.sv
module sim_nibble_mem_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] MASK = 7'h3F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [4:0] cmd_op = '0;
  logic [3:0] cmd_imm = '0;
  logic [3:0] acc_in = '0;
  logic [6:0] mem_addr;
  logic [3:0] mem_wdata;
  logic       mem_we;
  logic [7:0] mem_rdata;
  logic [2:0] x_out;
  logic [3:0] y_out;
  logic       res_valid, res_acc_we, res_zf_we, res_zf, res_cf_we, res_cf;
  logic [3:0] res_acc;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  int lat = 0;
  int we_d = 0;
  bit finished = 0;

  logic [7:0] ram [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_mem_unit #(.XW(3), .YW(4), .BUSW(8), .DATA_MASK(MASK)) u0 (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_imm(cmd_imm),
    .acc_in(acc_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .x_out(x_out), .y_out(y_out),
    .res_valid(res_valid), .res_acc_we(res_acc_we), .res_acc(res_acc),
    .res_zf_we(res_zf_we), .res_zf(res_zf), .res_cf_we(res_cf_we),
    .res_cf(res_cf)
  );

  assign mem_rdata = ram[mem_addr];

  always @(posedge clk) begin
    if (mem_we) begin
      ram[mem_addr] <= {4'hA, mem_wdata};
      we_cnt <= we_cnt + 1;
    end
  end

  function automatic logic [6:0] ix(input int x, input int y);
    return 7'((x << 4) | y) & MASK;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [4:0] op, input logic [3:0] imm, input logic [3:0] acc);
    int w0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_imm = imm; acc_in = acc;
    w0 = we_cnt;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!cmd_ready) begin @(negedge clk); lat++; end
    we_d = we_cnt - w0;
  endtask

  task automatic set_xy(input int x, input int y);
    do_op(5'd9, 4'(x), 4'h0);
    do_op(5'd10, 4'(y), 4'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) ram[i] = 8'((i * 37 + 11) ^ (i << 4));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(x_out == 0 && y_out == 0, "R1 xy", {x_out, y_out}, 0);
    chk(!res_valid && cmd_ready, "R1 ready/valid", {res_valid, cmd_ready}, 1);

    // R4 immediate loads of X and Y
    for (int v = 0; v < 16; v++) begin
      do_op(5'd9, 4'(v), 4'h0);
      chk(x_out == 3'(v), "R4 LX", x_out, v & 7);
      do_op(5'd10, 4'(v), 4'h0);
      chk(y_out == 4'(v), "R4 LY", y_out, v);
    end

    // R2 R5 indexed load sweep
    for (int x = 0; x < 8; x++) begin
      for (int y = 0; y < 16; y++) begin
        logic [3:0] e;
        set_xy(x, y);
        e = ram[ix(x, y)][3:0];
        do_op(5'd1, 4'h0, 4'h0);
        chk(res_valid && res_acc_we && res_acc == e, "R2 R5 load value", res_acc, e);
        chk(res_zf_we && res_zf == (e == 0), "R5 load zero", res_zf, e == 0);
        chk(lat == 1 && we_d == 0, "R12 load no write", we_d, 0);
      end
    end

    // R6 indexed store
    for (int x = 0; x < 8; x += 3) begin
      for (int y = 0; y < 16; y++) begin
        logic [3:0] d;
        d = 4'(x * 5 + y * 3 + 1);
        set_xy(x, y);
        do_op(5'd5, 4'h0, d);
        chk(ram[ix(x, y)][3:0] == d, "R2 R6 store data", ram[ix(x, y)][3:0], d);
        chk(we_d == 1 && lat == 1, "R6 R12 store one pulse", we_d, 1);
      end
    end

    // R3 direct access ignores X and Y
    set_xy(5, 9);
    for (int v = 0; v < 16; v++) begin
      logic [3:0] e;
      e = ram[v & 3][3:0];
      do_op(5'd2, 4'(v), 4'h0);
      chk(res_acc_we && res_acc == e, "R3 direct load", res_acc, e);
      do_op(5'd6, 4'(v), 4'(15 - v));
      chk(ram[v & 3][3:0] == 4'(15 - v), "R3 direct store", ram[v & 3][3:0], 15 - v);
      chk(x_out == 5 && y_out == 9, "R3 xy untouched", y_out, 9);
    end

    // R7 step variants over every Y
    for (int y = 0; y < 16; y++) begin
      logic [3:0] e;
      int ny;
      set_xy(6, y);
      e = ram[ix(6, y)][3:0];
      do_op(5'd3, 4'h0, 4'h0);
      ny = (y + 1) & 15;
      chk(res_acc_we && res_acc == e && lat == 2, "R7 load-inc value", res_acc, e);
      chk(y_out == 4'(ny) && res_zf == (ny == 0), "R7 load-inc Y", y_out, ny);
      set_xy(6, y);
      e = ram[ix(6, y)][3:0];
      do_op(5'd4, 4'h0, 4'h0);
      ny = (y + 15) & 15;
      chk(res_acc == e && y_out == 4'(ny) && res_zf == (ny == 0), "R7 load-dec", y_out, ny);
      set_xy(2, y);
      do_op(5'd7, 4'h0, 4'(y ^ 5));
      ny = (y + 1) & 15;
      chk(ram[ix(2, y)][3:0] == 4'(y ^ 5) && we_d == 1, "R7 store-inc data", ram[ix(2, y)][3:0], y ^ 5);
      chk(y_out == 4'(ny) && res_zf_we && res_zf == (ny == 0) && !res_acc_we, "R7 store-inc Y", y_out, ny);
      set_xy(2, y);
      do_op(5'd8, 4'h0, 4'(y ^ 9));
      ny = (y + 15) & 15;
      chk(ram[ix(2, y)][3:0] == 4'(y ^ 9) && y_out == 4'(ny) && res_zf == (ny == 0), "R7 store-dec", y_out, ny);
    end

    // R8 increment / decrement memory
    set_xy(3, 7);
    for (int v = 0; v < 16; v++) begin
      ram[ix(3, 7)] = {4'hC, 4'(v)};
      do_op(5'd14, 4'h0, 4'h0);
      chk(ram[ix(3, 7)][3:0] == 4'((v + 1) & 15) && we_d == 1 && lat == 2, "R8 inc data", ram[ix(3, 7)][3:0], (v + 1) & 15);
      chk(res_cf_we && res_cf == (v == 15) && res_zf == (v == 15), "R8 inc flags", {res_cf, res_zf}, (v == 15) ? 3 : 0);
      ram[ix(3, 7)] = {4'h3, 4'(v)};
      do_op(5'd15, 4'h0, 4'h0);
      chk(ram[ix(3, 7)][3:0] == 4'((v + 15) & 15) && we_d == 1, "R8 dec data", ram[ix(3, 7)][3:0], (v + 15) & 15);
      chk(res_cf == (v == 0) && res_zf == (v == 1), "R8 dec flags", {res_cf, res_zf}, {v == 0, v == 1});
    end

    // R9 set / clear bits
    set_xy(7, 15);
    for (int v = 0; v < 16; v++) begin
      for (int m = 0; m < 16; m++) begin
        ram[ix(7, 15)] = {4'h6, 4'(v)};
        do_op(5'd16, 4'(m), 4'h0);
        chk(ram[ix(7, 15)][3:0] == 4'(v | m) && we_d == 1 && !res_zf_we, "R9 set bits", ram[ix(7, 15)][3:0], v | m);
        ram[ix(7, 15)] = {4'h6, 4'(v)};
        do_op(5'd17, 4'(m), 4'h0);
        chk(ram[ix(7, 15)][3:0] == 4'(v & ~m) && lat == 2 && !res_cf_we, "R9 clear bits", ram[ix(7, 15)][3:0], v & ~m & 15);
      end
    end

    // R10 transfers
    for (int v = 0; v < 16; v++) begin
      do_op(5'd11, 4'h0, 4'(v));
      chk(x_out == 3'(v), "R10 acc to X", x_out, v & 7);
      do_op(5'd12, 4'h0, 4'(v));
      chk(y_out == 4'(v), "R10 acc to Y", y_out, v);
      do_op(5'd13, 4'h0, 4'h0);
      chk(res_acc_we && res_acc == 4'(v) && res_zf == (v == 0) && we_d == 0, "R10 Y to acc", res_acc, v);
    end

    // R11 stall in idle
    set_xy(1, 1);
    @(negedge clk);
    clk_en = 1'b0;
    cmd_valid = 1'b1; cmd_op = 5'd9; cmd_imm = 4'h6;
    repeat (3) begin
      @(negedge clk);
      chk(!cmd_ready && x_out == 1, "R11 idle stall", x_out, 1);
    end
    clk_en = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(x_out == 6, "R11 accept after stall", x_out, 6);

    // R11 stall inside a read-modify-write
    set_xy(0, 4);
    ram[ix(0, 4)] = 8'h37;
    begin
      int w0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 5'd14; w0 = we_cnt;
      @(negedge clk);
      cmd_valid = 1'b0; clk_en = 1'b0;
      repeat (3) begin
        @(negedge clk);
        chk(!cmd_ready && we_cnt == w0, "R11 phase-two stall", we_cnt - w0, 0);
      end
      clk_en = 1'b1;
      @(negedge clk);
      chk(cmd_ready && we_cnt == w0 + 1 && ram[ix(0, 4)][3:0] == 4'h8, "R11 R12 resume write", ram[ix(0, 4)][3:0], 8);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule